// File: doc/BRIEF.md
# Serial Port with Break and Error Handling

This block is a serial transmitter and receiver pair driven by a common base tick. The base tick runs at sixteen times the bit rate and comes from a fixed divider of the system clock. In asynchronous mode the transmitter sends framed characters and the receiver recovers them by oversampling. A simple clocked synchronous mode sends bare 8-bit characters together with a shift clock. Software-side control is a set of plain level and strobe inputs: transmit and receive enables, a transmit data write, a receive data read, and per-flag clear strobes for the sticky error flags.

When the transmitter is disabled, the line output is handed to a port data bit and a port direction bit. Software can then park the line at mark or drive it low on purpose to signal a break. The receiver treats an all-low line as a stream of characters whose stop bit is bad, so a break keeps raising the framing error for as long as it lasts. In synchronous mode the transmitter refuses to start a character while any receive error flag is set.

Top module: `serial_port`

## Requirements
- R1: A base tick occurs every CLKS_PER_TICK clocks, and each transmitted bit lasts 16 ticks. The asynchronous character is a low start bit, 8 data bits least significant first, an even parity bit when `par_en` is 1, and a high stop bit.
- R2: Writing `tdr_wr` loads the transmit data and clears `tdre` in the next cycle. A character begins at the first tick at which the transmitter is enabled and idle and `tdre` is 0, and `tdre` returns to 1 at that tick. Consecutive characters are separated by one tick of mark.
- R3: While `tx_en` is 0 the transmitter is held idle and `tdre` reads 1. Clearing `tx_en` abandons a character at once. `txd` then equals `port_dat` with `txd_oe`=1 when `port_dir` is 1; otherwise `txd_oe`=0 and `txd` reads 1.
- R4: In asynchronous mode the receiver detects a start bit on any tick at which the synchronised line is low while idle. It checks the start bit on the 8th tick after detection and samples every later bit 16 ticks apart.
- R5: If the line is high when the start bit is checked, the receiver returns to idle and no flag or data changes.
- R6: A completed character is placed on `rdr_data` and sets `rdr_full`; a `rdr_rd` pulse clears `rdr_full`.
- R7: With `par_en`=1, a received parity bit that differs from the even parity of the data sets `err_par`. The data is still delivered.
- R8: A stop bit sampled low sets `err_frm`. During a continuous break the receiver keeps receiving, so `err_frm` sets again after software clears it, and the delivered data is 0x00.
- R9: A character completing while `rdr_full` is 1 and no read is in progress sets `err_ovr` and leaves `rdr_data` unchanged.
- R10: The error flags are sticky. `err_clr` bit 0 clears `err_ovr`, bit 1 clears `err_par` and bit 2 clears `err_frm`. A set in the same cycle wins over a clear, and clearing `rx_en` leaves the flags untouched.
- R11: With `sync_mode`=1 a character is 8 data bits least significant first with no start, parity or stop bit, each 16 ticks long. `sck` is low for the first 8 ticks of each bit and high for the rest, and it idles high. The receiver is held idle in this mode.
- R12: With `sync_mode`=1, no character starts while any of `err_ovr`, `err_par` or `err_frm` is 1, even with `tdre` at 0. Transmission starts once all of them are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; 0 hands the line to port control |
| rx_en | input | 1 | Receiver enable |
| sync_mode | input | 1 | 1 selects clocked synchronous mode |
| par_en | input | 1 | Even parity bit enable (asynchronous mode) |
| port_dir | input | 1 | Port direction bit used while transmit is off |
| port_dat | input | 1 | Port data bit used while transmit is off |
| tdr_wr | input | 1 | Transmit data write strobe |
| tdr_data | input | 8 | Transmit data |
| rdr_rd | input | 1 | Receive data read strobe |
| err_clr | input | 3 | Flag clear strobes: [0] overrun, [1] parity, [2] framing |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| txd_oe | output | 1 | Transmit line output enable |
| sck | output | 1 | Synchronous mode shift clock |
| tdre | output | 1 | Transmit data register empty |
| rdr_full | output | 1 | Receive data waiting to be read |
| rdr_data | output | 8 | Received data |
| err_ovr | output | 1 | Overrun error flag |
| err_par | output | 1 | Parity error flag |
| err_frm | output | 1 | Framing error flag |

## Verification
A behavioural transmit model predicts `txd`, `txd_oe`, `sck` and `tdre` on every clock, including an abort part-way through a character. A design that let the frame run on after `tx_en` fell, or that started a synchronous character over a pending error, would diverge on the cycle it happened. The receive side is driven with a clean character, a bad parity bit, a low stop bit, two unread characters, a five-tick glitch and a held-low break. A receiver that needed a fresh falling edge would fail to raise the framing flag a second time during the break. A design that dropped the old byte on overrun, cleared flags when `rx_en` fell, or accepted the glitch as a start would report wrong data or spurious flags.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;

    localparam int TICKS_PER_BIT = 16;
    localparam int FRAME_MAX     = 11;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_t;

    typedef struct packed {
        logic frm;
        logic par;
        logic ovr;
    } err_flags_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [3:0]           last;
    } tx_frame_t;

    function automatic logic even_par(input logic [7:0] d);
        return ^d;
    endfunction

    function automatic tx_frame_t build_frame(input logic [7:0] d,
                                              input logic       with_par,
                                              input logic       sync);
        tx_frame_t f;
        f.bits = '1;
        if (sync) begin
            f.bits[7:0] = d;
            f.last      = 4'd7;
        end else begin
            f.bits[0]   = 1'b0;
            f.bits[8:1] = d;
            if (with_par) begin
                f.bits[9] = even_par(d);
                f.last    = 4'd10;
            end else begin
                f.last    = 4'd9;
            end
        end
        return f;
    endfunction

endpackage

// File: rtl/serial_port_tick.sv
module serial_port_tick #(
    parameter int CLKS_PER_TICK = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_TICK - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/serial_port_tx.sv
module serial_port_tx
    import serial_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       tx_en,
    input  logic       sync_mode,
    input  logic       par_en,
    input  logic       err_any,
    input  logic       tdr_wr,
    input  logic [7:0] tdr_data,
    output logic       line,
    output logic       sck,
    output logic       tdre,
    output logic       busy
);
    localparam int TW = $clog2(TICKS_PER_BIT);
    localparam logic [TW-1:0] TLAST = TW'(TICKS_PER_BIT - 1);
    localparam logic [TW-1:0] THALF = TW'(TICKS_PER_BIT / 2);

    logic [TW-1:0]        tcnt;
    logic [3:0]           bitcnt;
    logic [3:0]           lastbit;
    logic [FRAME_MAX-1:0] shreg;
    logic [7:0]           tdr;
    logic                 fsync;
    logic                 can_start;
    tx_frame_t            fr;

    always_comb begin
        fr        = build_frame(tdr, par_en, sync_mode);
        can_start = tick && !tdre && !(sync_mode && err_any);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            line    <= 1'b1;
            tdre    <= 1'b1;
            tdr     <= '0;
            shreg   <= '1;
            tcnt    <= '0;
            bitcnt  <= '0;
            lastbit <= '0;
            fsync   <= 1'b0;
        end else begin
            if (!tx_en) begin
                busy <= 1'b0;
                line <= 1'b1;
                tdre <= 1'b1;
            end else if (!busy) begin
                if (can_start) begin
                    busy    <= 1'b1;
                    line    <= fr.bits[0];
                    shreg   <= {1'b1, fr.bits[FRAME_MAX-1:1]};
                    tcnt    <= '0;
                    bitcnt  <= '0;
                    lastbit <= fr.last;
                    fsync   <= sync_mode;
                    tdre    <= 1'b1;
                end
            end else if (tick) begin
                if (tcnt == TLAST) begin
                    tcnt <= '0;
                    if (bitcnt == lastbit) begin
                        busy <= 1'b0;
                        line <= 1'b1;
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                        line   <= shreg[0];
                        shreg  <= {1'b1, shreg[FRAME_MAX-1:1]};
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
            if (tdr_wr) begin
                tdr  <= tdr_data;
                tdre <= 1'b0;
            end
        end
    end

    assign sck = !(busy && fsync) || (tcnt >= THALF);

    // R3
    tx_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !tdr_wr) |=> (!busy && tdre && line));

    // R12
    sync_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && sync_mode && err_any) |=> !busy);

    // R2
    start_empties_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && !$past(tdr_wr)) |-> tdre);
endmodule

// File: rtl/serial_port_rx.sv
module serial_port_rx
    import serial_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       run,
    input  logic       par_en,
    input  logic       rxd,
    input  logic       rdr_rd,
    input  logic [2:0] err_clr,
    output logic [7:0] rdr_data,
    output logic       rdr_full,
    output err_flags_t flags
);
    localparam int TW = $clog2(TICKS_PER_BIT);
    localparam logic [TW-1:0] TLAST = TW'(TICKS_PER_BIT - 1);
    localparam logic [TW-1:0] TMID  = TW'(TICKS_PER_BIT / 2 - 1);

    logic [1:0]  sy;
    logic        rxs;
    rx_state_t   state;
    logic [TW-1:0] cnt;
    logic [2:0]  bitn;
    logic [7:0]  shreg;
    logic        par_bit;
    logic        bit_due;
    logic        finish;
    err_flags_t  set_f;

    assign rxs = sy[1];

    always_ff @(posedge clk) begin
        if (rst) sy <= 2'b11;
        else     sy <= {sy[0], rxd};
    end

    always_comb begin
        bit_due   = tick && (cnt == TLAST);
        finish    = (state == RX_STOP) && bit_due;
        set_f.ovr = finish && rdr_full && !rdr_rd;
        set_f.frm = finish && !rxs;
        set_f.par = finish && par_en && (par_bit != even_par(shreg));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            if (rst) begin
                shreg   <= '0;
                par_bit <= 1'b0;
            end
        end else begin
            unique case (state)
                RX_IDLE: if (tick && !rxs) begin
                    state <= RX_START;
                    cnt   <= '0;
                end
                RX_START: if (tick) begin
                    if (cnt == TMID) begin
                        cnt   <= '0;
                        bitn  <= '0;
                        state <= rxs ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: if (tick) begin
                    if (bit_due) begin
                        cnt   <= '0;
                        shreg <= {rxs, shreg[7:1]};
                        bitn  <= bitn + 1'b1;
                        if (bitn == 3'd7) state <= par_en ? RX_PAR : RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_PAR: if (tick) begin
                    if (bit_due) begin
                        cnt     <= '0;
                        par_bit <= rxs;
                        state   <= RX_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: if (tick) begin
                    if (bit_due) begin
                        cnt   <= '0;
                        state <= RX_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdr_data <= '0;
            rdr_full <= 1'b0;
            flags    <= '0;
        end else begin
            if (finish && (!rdr_full || rdr_rd)) rdr_data <= shreg;
            if (finish)      rdr_full <= 1'b1;
            else if (rdr_rd) rdr_full <= 1'b0;
            flags.ovr <= set_f.ovr | (flags.ovr & !err_clr[0]);
            flags.par <= set_f.par | (flags.par & !err_clr[1]);
            flags.frm <= set_f.frm | (flags.frm & !err_clr[2]);
        end
    end

    // R8
    frm_at_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.frm) |-> ($past(state) == RX_STOP));

    // R9
    ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.ovr) |-> $stable(rdr_data));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && err_clr == 3'b000) |=> $stable(flags));

    // R5
    glitch_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && tick && cnt == TMID && rxs) |=> (state == RX_IDLE && !rdr_full == !$past(rdr_full)));
endmodule

// File: rtl/serial_port.sv
module serial_port
    import serial_port_pkg::*;
#(
    parameter int CLKS_PER_TICK = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       sync_mode,
    input  logic       par_en,
    input  logic       port_dir,
    input  logic       port_dat,
    input  logic       tdr_wr,
    input  logic [7:0] tdr_data,
    input  logic       rdr_rd,
    input  logic [2:0] err_clr,
    input  logic       rxd,
    output logic       txd,
    output logic       txd_oe,
    output logic       sck,
    output logic       tdre,
    output logic       rdr_full,
    output logic [7:0] rdr_data,
    output logic       err_ovr,
    output logic       err_par,
    output logic       err_frm
);
    logic       tick;
    logic       tx_line;
    logic       tx_busy;
    err_flags_t flags;

    serial_port_tick #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    serial_port_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .tx_en     (tx_en),
        .sync_mode (sync_mode),
        .par_en    (par_en),
        .err_any   (|flags),
        .tdr_wr    (tdr_wr),
        .tdr_data  (tdr_data),
        .line      (tx_line),
        .sck       (sck),
        .tdre      (tdre),
        .busy      (tx_busy)
    );

    serial_port_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .run      (rx_en && !sync_mode),
        .par_en   (par_en),
        .rxd      (rxd),
        .rdr_rd   (rdr_rd),
        .err_clr  (err_clr),
        .rdr_data (rdr_data),
        .rdr_full (rdr_full),
        .flags    (flags)
    );

    assign txd     = tx_en ? tx_line : (port_dir ? port_dat : 1'b1);
    assign txd_oe  = tx_en | port_dir;
    assign err_ovr = flags.ovr;
    assign err_par = flags.par;
    assign err_frm = flags.frm;

    // R3
    port_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !port_dir) |-> (txd && !txd_oe));

    // R11
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> sck);
endmodule

// File: tb/serial_port_bench.sv
module serial_port_bench;
    localparam int DIV = 4;
    localparam int BITCLK = 16 * DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_en = 0, rx_en = 0, sync_mode = 0, par_en = 0;
    logic port_dir = 0, port_dat = 1;
    logic tdr_wr = 0;
    logic [7:0] tdr_data = 0;
    logic rdr_rd = 0;
    logic [2:0] err_clr = 0;
    logic rxd = 1;
    logic txd, txd_oe, sck, tdre, rdr_full, err_ovr, err_par, err_frm;
    logic [7:0] rdr_data;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    serial_port #(.CLKS_PER_TICK(DIV)) u_serial_port (
        .clk(clk), .rst(rst), .tx_en(tx_en), .rx_en(rx_en),
        .sync_mode(sync_mode), .par_en(par_en), .port_dir(port_dir),
        .port_dat(port_dat), .tdr_wr(tdr_wr), .tdr_data(tdr_data),
        .rdr_rd(rdr_rd), .err_clr(err_clr), .rxd(rxd), .txd(txd),
        .txd_oe(txd_oe), .sck(sck), .tdre(tdre), .rdr_full(rdr_full),
        .rdr_data(rdr_data), .err_ovr(err_ovr), .err_par(err_par),
        .err_frm(err_frm)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural transmit model
    int        dcnt = 0;
    bit        m_busy = 0, m_line = 1, m_tdre = 1, m_sync = 0;
    int        m_idx = 0, m_nbits = 0;
    bit [10:0] m_frame = '1;
    bit [7:0]  m_tdr = 0;

    always @(posedge clk) begin
        bit tk;
        if (rst) begin
            dcnt = 0; m_busy = 0; m_line = 1; m_tdre = 1; m_tdr = 0;
        end else begin
            tk = (dcnt == DIV - 1);
            dcnt = tk ? 0 : dcnt + 1;
            if (!tx_en) begin
                m_busy = 0; m_line = 1; m_tdre = 1;
            end else if (!m_busy) begin
                if (tk && !m_tdre && !(sync_mode && (err_ovr || err_par || err_frm))) begin
                    m_frame = '1;
                    if (sync_mode) begin
                        m_frame[7:0] = m_tdr; m_nbits = 8;
                    end else begin
                        m_frame[0] = 0;
                        m_frame[8:1] = m_tdr;
                        if (par_en) begin m_frame[9] = ^m_tdr; m_nbits = 11; end
                        else m_nbits = 10;
                    end
                    m_sync = sync_mode;
                    m_busy = 1; m_idx = 0; m_line = m_frame[0]; m_tdre = 1;
                end
            end else if (tk) begin
                m_idx++;
                if (m_idx == 16 * m_nbits) begin m_busy = 0; m_line = 1; end
                else m_line = m_frame[m_idx / 16];
            end
            if (tdr_wr) begin m_tdr = tdr_data; m_tdre = 0; end
        end
        #2;
        if (!rst && !done) begin
            bit e_txd, e_oe, e_sck;
            e_txd = tx_en ? m_line : (port_dir ? port_dat : 1'b1);
            e_oe  = tx_en | port_dir;
            e_sck = (m_busy && m_sync) ? ((m_idx % 16) >= 8) : 1'b1;
            chk(txd == e_txd, "R1 txd", txd, e_txd);
            chk(txd_oe == e_oe, "R3 txd_oe", txd_oe, e_oe);
            chk(sck == e_sck, "R11 sck", sck, e_sck);
            chk(tdre == m_tdre, "R2 tdre", tdre, m_tdre);
        end
    end

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); tdr_wr = 1; tdr_data = d;
        @(negedge clk); tdr_wr = 0;
    endtask

    task automatic rd_byte();
        @(negedge clk); rdr_rd = 1;
        @(negedge clk); rdr_rd = 0;
    endtask

    task automatic clr_flags(input logic [2:0] m);
        @(negedge clk); err_clr = m;
        @(negedge clk); err_clr = 0;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] d, input bit with_par, input bit flip, input bit stopv);
        @(negedge clk);
        rxd = 0; wait_clks(BITCLK);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; wait_clks(BITCLK); end
        if (with_par) begin rxd = (^d) ^ flip; wait_clks(BITCLK); end
        rxd = stopv; wait_clks(BITCLK);
        rxd = 1; wait_clks(4);
    endtask

    initial begin
        repeat (100000) @(negedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_clks(5);
        rst = 0;
        wait_clks(2);
        // reset state (R3 R6 R10)
        chk(txd == 1 && txd_oe == 0, "R3 reset line", {txd, txd_oe}, 2'b10);
        chk(tdre == 1, "R3 reset tdre", tdre, 1);
        chk(rdr_full == 0, "R6 reset full", rdr_full, 0);
        chk({err_ovr, err_par, err_frm} == 0, "R10 reset flags", {err_ovr, err_par, err_frm}, 0);

        // port control (R3)
        port_dir = 1; port_dat = 1; wait_clks(1);
        chk(txd == 1 && txd_oe == 1, "R3 mark", {txd, txd_oe}, 2'b11);
        port_dat = 0; wait_clks(1);
        chk(txd == 0 && txd_oe == 1, "R3 break out", {txd, txd_oe}, 2'b01);

        // async transmit (R1 R2)
        tx_en = 1;
        wr_byte(8'hA5);
        wait_clks(11 * BITCLK);
        chk(tdre == 1, "R2 tdre after frame", tdre, 1);
        par_en = 1;
        wr_byte(8'h3C);
        while (!tdre) @(negedge clk);
        wr_byte(8'hC3);
        wait_clks(24 * BITCLK);

        // abort (R3)
        wr_byte(8'h0F);
        wait_clks(5 * BITCLK);
        port_dat = 1; tx_en = 0;
        wait_clks(2);
        chk(tdre == 1 && txd == 1, "R3 abort", {tdre, txd}, 2'b11);
        tx_en = 1; par_en = 0;
        wait_clks(BITCLK);
        chk(txd == 1, "R3 no resume", txd, 1);

        // receive clean (R4 R6)
        rx_en = 1;
        send_rx(8'h5A, 0, 0, 1);
        chk(rdr_full == 1 && rdr_data == 8'h5A, "R4 data", rdr_data, 8'h5A);
        chk({err_ovr, err_par, err_frm} == 0, "R6 no flags", {err_ovr, err_par, err_frm}, 0);
        rd_byte();
        chk(rdr_full == 0, "R6 read clears", rdr_full, 0);

        // parity (R7)
        par_en = 1;
        send_rx(8'h81, 1, 0, 1);
        chk(err_par == 0 && rdr_data == 8'h81, "R7 good parity", {err_par, rdr_data}, 9'h081);
        rd_byte();
        send_rx(8'h81, 1, 1, 1);
        chk(err_par == 1, "R7 bad parity", err_par, 1);
        chk(rdr_data == 8'h81, "R7 data kept", rdr_data, 8'h81);
        rd_byte();
        par_en = 0;

        // framing (R8)
        send_rx(8'h33, 0, 0, 0);
        chk(err_frm == 1, "R8 low stop", err_frm, 1);
        rd_byte();
        clr_flags(3'b111);
        chk({err_ovr, err_par, err_frm} == 0, "R10 clear", {err_ovr, err_par, err_frm}, 0);

        // overrun (R9) and rx_en off (R10)
        send_rx(8'h11, 0, 0, 1);
        send_rx(8'h22, 0, 0, 1);
        chk(err_ovr == 1, "R9 overrun", err_ovr, 1);
        chk(rdr_data == 8'h11, "R9 old data kept", rdr_data, 8'h11);
        rx_en = 0; wait_clks(20);
        chk(err_ovr == 1, "R10 rx_en off keeps", err_ovr, 1);
        rx_en = 1;
        rd_byte();
        clr_flags(3'b111);

        // glitch (R5)
        rxd = 0; wait_clks(5 * DIV); rxd = 1;
        wait_clks(2 * BITCLK);
        chk(rdr_full == 0, "R5 glitch no data", rdr_full, 0);
        chk({err_ovr, err_par, err_frm} == 0, "R5 glitch no flags", {err_ovr, err_par, err_frm}, 0);

        // break (R8)
        rxd = 0;
        wait_clks(11 * BITCLK);
        chk(err_frm == 1, "R8 break framing", err_frm, 1);
        chk(rdr_data == 8'h00, "R8 break data", rdr_data, 0);
        rd_byte();
        clr_flags(3'b100);
        chk(err_frm == 0, "R8 cleared", err_frm, 0);
        wait_clks(11 * BITCLK);
        chk(err_frm == 1, "R8 break sets again", err_frm, 1);
        rx_en = 0; rxd = 1;
        wait_clks(4);

        // synchronous interlock (R12) and shift clock (R11)
        sync_mode = 1;
        wr_byte(8'h96);
        wait_clks(40 * DIV);
        chk(tdre == 0 && txd == 1, "R12 blocked", {tdre, txd}, 2'b01);
        clr_flags(3'b111);
        wait_clks(9 * BITCLK);
        chk(tdre == 1, "R11 sync sent", tdre, 1);
        chk(sck == 1, "R11 sck idle", sck, 1);

        done = 1;
        wait_clks(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule